// File: doc/BRIEF.md
# Shared-Bus Multiplexed DRAM Controller

This block drives an array of multiplexed-address DRAM that two requesters share: a CPU and a video fetcher. They take turns in fixed time slots of seven master-clock cycles. A CPU slot is always followed by a video slot, and a video slot by a CPU slot. In each slot the block takes the 16-bit byte address of the slot's owner. It puts the low seven address bits on the shared DRAM address lines as the row and strobes one common row strobe. It then switches the lines to the next seven bits as the column and strobes the column strobe of the single addressed bank. Each bank is eight one-bit devices, one per data line. The block captures read data and hands it back to the owner.

There is no refresh engine. Every slot strobes a row in every device, whichever bank is addressed. The video fetcher walks through many row values, so the normal traffic keeps the whole array refreshed. An address above the three 16 KB banks gives a row-strobe-only cycle, and that cycle still refreshes a row. A built-in coverage monitor records which of the 128 row values were strobed. It raises a sticky flag when a window of cycles ends without all of them.

Top module: `shared_dram_ctrl`

## Requirements
- R1: Slot cycles are numbered 0 to 6. In cycle 0, `dram_addr` carries address bits [6:0] (the row). In cycles 1 to 5 it carries address bits [13:7] (the column).
- R2: `ras_n` is one strobe shared by all banks. It is low in cycles 0 to 5 of every slot, whatever bank is addressed.
- R3: The bank is address bits [15:14]. For banks 0 to 2, only `cas_n[bank]` goes low, in cycles 2 to 5. For bank 3 (0xC000 and up), no column strobe goes low.
- R4: In cycle 6, `ras_n` and all of `cas_n` are high together.
- R5: Slots last 7 cycles and alternate between owners. `cpu_phase` is 1 during CPU slots. The first slot after reset belongs to the CPU.
- R6: A read in banks 0 to 2 returns its data, captured at the end of cycle 5. It appears on `cpu_rdata` or `vid_rdata` with a one-cycle `cpu_rvalid` or `vid_rvalid` pulse in cycle 6. Bank-3 accesses and writes give no valid pulse.
- R7: `we_n` is low in cycles 1 to 5 of CPU slots that carry a write, so it falls before the column strobe. It is never low in video slots. `dram_dout` then carries the write data.
- R8: A row-strobe-only cycle (bank 3) counts toward refresh coverage just as a full access does.
- R9: `refresh_err` goes high after a window of REFRESH_WINDOW cycles ends without all 128 row values strobed. It stays high until reset.
- R10: While reset is applied, `ras_n` and `we_n` are high, `cas_n` is 3'b111, and both valid pulses and `refresh_err` are low.
- R11: The owner's address, write flag and write data are sampled at the clock edge that opens its slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wr | input | 1 | CPU write request |
| cpu_wdata | input | 8 | CPU write data |
| vid_addr | input | 16 | Video fetch address |
| dram_din | input | 8 | Data from DRAM array |
| dram_addr | output | 7 | Multiplexed row/column address |
| ras_n | output | 1 | Common row strobe, active low |
| cas_n | output | 3 | Per-bank column strobes, active low |
| we_n | output | 1 | Write enable, active low |
| dram_dout | output | 8 | Data to DRAM array |
| cpu_phase | output | 1 | High during CPU slots |
| cpu_rdata | output | 8 | CPU read data |
| cpu_rvalid | output | 1 | CPU read data valid pulse |
| vid_rdata | output | 8 | Video read data |
| vid_rvalid | output | 1 | Video read data valid pulse |
| refresh_err | output | 1 | Sticky refresh coverage error |

## Verification
A coverage window can close in the same cycle as a row strobe. That strobe must count in the new window and not be lost. The default window length is not a multiple of the 7-cycle slot, so this coincidence recurs across the long runs. In the first run, the video fetcher sweeps the rows while the CPU makes random accesses. In the second, only CPU bank-3 row-strobe-only cycles sweep the rows. In both runs `refresh_err` must stay low over several windows. A third run holds both addresses fixed and must set the flag.

// File: rtl/shdram_pkg.sv
package shdram_pkg;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 8;
  localparam int ROW_W      = 7;
  localparam int COL_W      = 7;
  localparam int BANK_W     = ADDR_W - ROW_W - COL_W;
  localparam int BANKS      = 3;
  localparam int SLOT_TICKS = 7;
  localparam int TICK_W     = $clog2(SLOT_TICKS);

  localparam logic [TICK_W-1:0] T_ROW  = TICK_W'(0);
  localparam logic [TICK_W-1:0] T_COL  = TICK_W'(1);
  localparam logic [TICK_W-1:0] T_CAS  = TICK_W'(2);
  localparam logic [TICK_W-1:0] T_CAPT = TICK_W'(5);
  localparam logic [TICK_W-1:0] T_LAST = TICK_W'(SLOT_TICKS - 1);

  typedef enum logic {OWN_VID = 1'b0, OWN_CPU = 1'b1} owner_e;
endpackage

// File: rtl/slot_sequencer.sv
module slot_sequencer
  import shdram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [TICK_W-1:0] tick,
  output owner_e            owner
);
  logic [TICK_W-1:0] tick_d;
  owner_e            owner_d;

  always_comb begin
    tick_d  = tick + TICK_W'(1);
    owner_d = owner;
    if (tick == T_LAST) begin
      tick_d  = T_ROW;
      owner_d = (owner == OWN_CPU) ? OWN_VID : OWN_CPU;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick  <= T_LAST;
      owner <= OWN_VID;
    end else begin
      tick  <= tick_d;
      owner <= owner_d;
    end
  end

  p_tick_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick <= T_LAST);
  p_owner_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick != T_LAST) |=> $stable(owner));
endmodule

// File: rtl/access_path.sv
module access_path
  import shdram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] tick,
  input  owner_e            owner,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [ADDR_W-1:0] vid_addr,
  input  logic [DATA_W-1:0] dram_din,
  output logic [ROW_W-1:0]  dram_addr,
  output logic              ras_n,
  output logic [BANKS-1:0]  cas_n,
  output logic              we_n,
  output logic [DATA_W-1:0] dram_dout,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] vid_rdata,
  output logic              vid_rvalid,
  output logic              row_strobe,
  output logic [ROW_W-1:0]  strobe_row
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              wr_q, wr_d;
  logic [DATA_W-1:0] wd_q, wd_d;
  logic              load_en, capt_en, in_range;
  logic              ras_act, cas_act, col_sel;
  logic [BANK_W-1:0] bank;
  logic [DATA_W-1:0] cpu_rdata_d, vid_rdata_d;
  logic              cpu_rvalid_d, vid_rvalid_d;

  assign load_en  = (tick == T_LAST);
  assign capt_en  = (tick == T_CAPT);
  assign bank     = addr_q[ADDR_W-1 -: BANK_W];
  assign in_range = (bank < BANK_W'(BANKS));
  assign ras_act  = (tick <= T_CAPT);
  assign cas_act  = (tick >= T_CAS) && (tick <= T_CAPT);
  assign col_sel  = (tick >= T_COL);

  // next slot owner is the opposite of the current one
  always_comb begin
    addr_d = addr_q;
    wr_d   = wr_q;
    wd_d   = wd_q;
    if (load_en) begin
      if (owner == OWN_VID) begin
        addr_d = cpu_addr;
        wr_d   = cpu_wr;
        wd_d   = cpu_wdata;
      end else begin
        addr_d = vid_addr;
        wr_d   = 1'b0;
        wd_d   = '0;
      end
    end
  end

  always_comb begin
    cpu_rdata_d  = cpu_rdata;
    vid_rdata_d  = vid_rdata;
    cpu_rvalid_d = 1'b0;
    vid_rvalid_d = 1'b0;
    if (capt_en && in_range && !wr_q) begin
      if (owner == OWN_CPU) begin
        cpu_rdata_d  = dram_din;
        cpu_rvalid_d = 1'b1;
      end else begin
        vid_rdata_d  = dram_din;
        vid_rvalid_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      wr_q       <= 1'b0;
      wd_q       <= '0;
      cpu_rdata  <= '0;
      vid_rdata  <= '0;
      cpu_rvalid <= 1'b0;
      vid_rvalid <= 1'b0;
    end else begin
      addr_q     <= addr_d;
      wr_q       <= wr_d;
      wd_q       <= wd_d;
      cpu_rdata  <= cpu_rdata_d;
      vid_rdata  <= vid_rdata_d;
      cpu_rvalid <= cpu_rvalid_d;
      vid_rvalid <= vid_rvalid_d;
    end
  end

  assign dram_addr  = col_sel ? addr_q[ROW_W +: COL_W] : addr_q[ROW_W-1:0];
  assign ras_n      = !ras_act;
  assign we_n       = !(wr_q && col_sel && ras_act);
  assign dram_dout  = wd_q;
  assign row_strobe = (tick == T_ROW);
  assign strobe_row = addr_q[ROW_W-1:0];

  for (genvar b = 0; b < BANKS; b++) begin : g_cas
    assign cas_n[b] = !(cas_act && (bank == BANK_W'(b)));
  end

  p_cas_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cas_n));
  p_cas_inside_ras_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n != '1) |-> !ras_n);
  p_release_together_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (cas_n == '1));
  p_we_cpu_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (owner == OWN_CPU));
  p_we_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(&cas_n) && !we_n) |-> !$past(we_n));
  p_row_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> ($past(tick) == T_LAST));
endmodule

// File: rtl/refresh_monitor.sv
module refresh_monitor
  import shdram_pkg::*;
#(
  parameter int WINDOW = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [ROW_W-1:0] row,
  output logic             err
);
  localparam int ROWS  = 1 << ROW_W;
  localparam int CNT_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;

  logic [ROWS-1:0]  seen, seen_d, hit_vec, merged;
  logic [CNT_W-1:0] cnt, cnt_d;
  logic             err_d, win_end;

  assign hit_vec = strobe ? (ROWS'(1) << row) : '0;
  assign merged  = seen | hit_vec;
  assign win_end = (cnt == CNT_W'(WINDOW - 1));

  // a strobe on the closing cycle belongs to the new window
  always_comb begin
    cnt_d  = cnt + CNT_W'(1);
    seen_d = merged;
    err_d  = err;
    if (win_end) begin
      cnt_d  = '0;
      seen_d = hit_vec;
      err_d  = err | ~(&seen);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      seen <= '0;
      err  <= 1'b0;
    end else begin
      cnt  <= cnt_d;
      seen <= seen_d;
      err  <= err_d;
    end
  end

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  p_err_on_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> ($past(cnt) == CNT_W'(WINDOW - 1)));
endmodule

// File: rtl/shared_dram_ctrl.sv
module shared_dram_ctrl
  import shdram_pkg::*;
#(
  parameter int REFRESH_WINDOW = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [ADDR_W-1:0] vid_addr,
  input  logic [DATA_W-1:0] dram_din,
  output logic [ROW_W-1:0]  dram_addr,
  output logic              ras_n,
  output logic [BANKS-1:0]  cas_n,
  output logic              we_n,
  output logic [DATA_W-1:0] dram_dout,
  output logic              cpu_phase,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] vid_rdata,
  output logic              vid_rvalid,
  output logic              refresh_err
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [TICK_W-1:0] tick;
  owner_e            owner;
  logic              row_strobe;
  logic [ROW_W-1:0]  strobe_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  slot_sequencer u_seq (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick  (tick),
    .owner (owner)
  );

  access_path u_path (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tick       (tick),
    .owner      (owner),
    .cpu_addr   (cpu_addr),
    .cpu_wr     (cpu_wr),
    .cpu_wdata  (cpu_wdata),
    .vid_addr   (vid_addr),
    .dram_din   (dram_din),
    .dram_addr  (dram_addr),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .dram_dout  (dram_dout),
    .cpu_rdata  (cpu_rdata),
    .cpu_rvalid (cpu_rvalid),
    .vid_rdata  (vid_rdata),
    .vid_rvalid (vid_rvalid),
    .row_strobe (row_strobe),
    .strobe_row (strobe_row)
  );

  refresh_monitor #(.WINDOW(REFRESH_WINDOW)) u_mon (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .strobe (row_strobe),
    .row    (strobe_row),
    .err    (refresh_err)
  );

  assign cpu_phase = (owner == OWN_CPU);

  p_rvalid_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(cpu_rvalid && vid_rvalid));
endmodule

// File: tb/sim_shared_dram_ctrl.sv
module sim_shared_dram_ctrl;
  localparam int BANK_SZ = 16384;
  localparam int MEM_SZ  = 3 * BANK_SZ;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr, vid_addr;
  logic        cpu_wr;
  logic [7:0]  cpu_wdata, dram_din, dram_dout, cpu_rdata, vid_rdata;
  logic [6:0]  dram_addr;
  logic        ras_n, we_n, cpu_phase, cpu_rvalid, vid_rvalid, refresh_err;
  logic [2:0]  cas_n;

  shared_dram_ctrl u0 (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  logic [7:0] smem [0:MEM_SZ-1];
  logic [7:0] rmem [0:MEM_SZ-1];
  int  sbank = 0;
  logic [6:0] srow = '0, scol = '0;
  bit  prev_ras = 1'b1, prev_cas_idle = 1'b1;

  assign dram_din = (cas_n != 3'b111) ? smem[sbank * BANK_SZ + int'({scol, srow})] : 8'h00;

  int  k = 0;
  bit  started = 1'b0, last_cpu = 1'b0;
  bit  s_cpu, s_wr;
  logic [15:0] s_addr;
  logic [7:0]  s_wd, s_exp;
  logic [6:0]  vrow = '0, crow = '0;

  function automatic int midx(input logic [15:0] a);
    return int'(a[15:14]) * BANK_SZ + int'(a[13:0]);
  endfunction

  function automatic logic [2:0] exp_cas(input logic [15:0] a);
    if (a[15:14] == 2'd3) return 3'b111;
    return ~(3'b001 << a[15:14]);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic new_cpu(input int mode);
    if (mode == 0) begin
      cpu_addr  = {2'($urandom % 4), 5'd0, 2'($urandom % 4), 4'd0, 3'($urandom % 8)};
      cpu_wr    = 1'($urandom % 2);
      cpu_wdata = 8'($urandom);
    end else if (mode == 1) begin
      cpu_addr  = {2'b11, 7'd5, crow};
      crow      = crow + 7'd1;
      cpu_wr    = 1'($urandom % 2);
      cpu_wdata = 8'($urandom);
    end else begin
      cpu_addr = 16'h1234; cpu_wr = 1'b0; cpu_wdata = 8'h00;
    end
  endtask

  task automatic new_vid(input int mode);
    if (mode == 0) begin
      vid_addr = {2'($urandom % 3), 7'($urandom % 4), vrow};
      vrow     = vrow + 7'd1;
    end else vid_addr = 16'h0203;
  endtask

  task automatic cycle(input int mode);
    @(negedge clk);
    cycles++;
    // behavioural DRAM stub
    if (prev_ras && !ras_n) srow = dram_addr;
    if (prev_cas_idle && cas_n != 3'b111) begin
      sbank = (!cas_n[0]) ? 0 : (!cas_n[1]) ? 1 : 2;
      scol  = dram_addr;
      if (!we_n) smem[sbank * BANK_SZ + int'({scol, srow})] = dram_dout;
    end
    if (prev_ras && !ras_n) begin
      if (started) begin
        chk(k == 6, "R5", "slot length", k + 1, 7);
        chk(cpu_phase != last_cpu, "R5", "owner alternation", cpu_phase, !last_cpu);
      end else chk(cpu_phase, "R5", "first owner cpu", cpu_phase, 1);
      started  = 1'b1;
      k        = 0;
      last_cpu = cpu_phase;
      s_cpu    = cpu_phase;
      s_addr   = s_cpu ? cpu_addr : vid_addr;
      s_wr     = s_cpu ? cpu_wr : 1'b0;
      s_wd     = cpu_wdata;
      s_exp    = (s_addr[15:14] != 2'd3) ? rmem[midx(s_addr)] : 8'h00;
      if (s_wr && s_addr[15:14] != 2'd3) rmem[midx(s_addr)] = s_wd;
      chk(dram_addr == s_addr[6:0], "R1", "row address", dram_addr, s_addr[6:0]);
      chk(cas_n == 3'b111 && we_n, "R7", "no cas/we at row cycle", {cas_n, we_n}, 4'hF);
      if (s_cpu) new_cpu(mode); else new_vid(mode);
    end else if (started) begin
      k++;
      if (k >= 1 && k <= 5) begin
        chk(!ras_n, "R2", "ras held", ras_n, 0);
        chk(dram_addr == s_addr[13:7], "R1", "column address", dram_addr, s_addr[13:7]);
        chk(we_n == !(s_cpu && s_wr), "R7", "write enable", we_n, !(s_cpu && s_wr));
        if (s_wr) chk(dram_dout == s_wd, "R7", "write data", dram_dout, s_wd);
        if (k == 1) chk(cas_n == 3'b111, "R3", "cas idle tick1", cas_n, 3'b111);
        else chk(cas_n == exp_cas(s_addr), "R3", "bank cas", cas_n, exp_cas(s_addr));
      end else if (k == 6) begin
        chk(ras_n && cas_n == 3'b111, "R4", "release", {ras_n, cas_n}, 4'hF);
        chk(cpu_rvalid == (s_cpu && !s_wr && s_addr[15:14] != 2'd3), "R6", "cpu rvalid",
            cpu_rvalid, s_cpu && !s_wr && s_addr[15:14] != 2'd3);
        chk(vid_rvalid == (!s_cpu && s_addr[15:14] != 2'd3), "R6", "vid rvalid",
            vid_rvalid, !s_cpu && s_addr[15:14] != 2'd3);
        if (cpu_rvalid) chk(cpu_rdata == s_exp, "R6", "cpu rdata R11", cpu_rdata, s_exp);
        if (vid_rvalid) chk(vid_rdata == s_exp, "R6", "vid rdata R11", vid_rdata, s_exp);
      end
    end
    prev_ras      = ras_n;
    prev_cas_idle = (cas_n == 3'b111);
  endtask

  task automatic do_reset(input int mode);
    rst_n = 1'b0;
    new_cpu(mode);
    new_vid(mode);
    repeat (3) @(negedge clk);
    chk(ras_n && we_n && cas_n == 3'b111, "R10", "strobes idle", {ras_n, we_n, cas_n}, 5'h1F);
    chk(!cpu_rvalid && !vid_rvalid && !refresh_err, "R10", "flags low",
        {cpu_rvalid, vid_rvalid, refresh_err}, 0);
    rst_n = 1'b1;
    started = 1'b0; prev_ras = 1'b1; prev_cas_idle = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < MEM_SZ; i++) begin
      smem[i] = 8'(i ^ (i >> 8));
      rmem[i] = 8'(i ^ (i >> 8));
    end
    do_reset(0);
    repeat (21000) cycle(0);
    chk(!refresh_err, "R9", "video sweep keeps coverage", refresh_err, 0);
    do_reset(1);
    repeat (10000) cycle(1);
    chk(!refresh_err, "R8", "ras-only sweep keeps coverage", refresh_err, 0);
    do_reset(2);
    repeat (10000) cycle(2);
    chk(refresh_err, "R9", "fixed rows flag error", refresh_err, 1);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 41000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule